// File: doc/BRIEF.md
# Sync-Tip Gain Loop with White-Peak Ceiling

This block closes a digital gain-control loop around an 8-bit video sample stream. It produces a gain code for an external amplifier. The loop raises the gain until the lowest sample seen inside an externally supplied sync-tip window reaches code 0. It also lowers the gain whenever bright picture content would push the converter past a ceiling of code 248. The ceiling check can be switched off with an enable input. The sync-tip target then acts alone, and samples may reach full scale.

Gain decisions are made once per line, at a line strobe. A pending white-peak reduction always beats a sync-tip increase. The gain code saturates at both ends and never wraps. Two status flags, held for one line, tell downstream logic whether the line just closed called for a white-peak reduction and whether its sync tip already sat at code 0.

Top module: `sync_agc`

## Requirements
- R1: Reset sets the gain code to its midpoint, 2^(GAIN_W-1), and clears both flags.
- R2: At a line strobe, if the line held at least one window sample, every window sample was above 0 and no white-peak reduction is pending, the gain rises by TIP_STEP. Samples outside the window, and the sample in the strobe cycle itself, do not count.
- R3: If the smallest window sample of the line was 0, the sync tip causes no increase and tip_floor is 1 for the next line. Otherwise tip_floor is 0.
- R4: A line with no window samples leaves the gain unchanged unless a white-peak reduction applies.
- R5: With peak_en high on a cycle whose sample exceeds PEAK_LEVEL (248), the next strobe lowers the gain by PEAK_STEP. A sample of exactly 248 does not trigger this.
- R6: A pending white-peak reduction takes priority over a sync-tip increase on the same line.
- R7: A sample above the ceiling has no effect on a cycle where peak_en is low, including 255. The enable is judged on each sample separately.
- R8: The gain saturates at 0 and at 2^GAIN_W-1 and never wraps.
- R9: The gain code and flags change only on the clock edge that samples line_stb high, and they hold for the rest of the line.
- R10: peak_line is 1 for the line after each line on which a white-peak reduction was requested, even when the gain is already at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | SAMPLE_W | Digitised video sample |
| tip_win | input | 1 | Sync-tip measurement window, high while the tip is present |
| line_stb | input | 1 | One-cycle strobe that closes a line and applies the decision |
| peak_en | input | 1 | White-peak ceiling enable |
| gain_code | output | GAIN_W | Amplifier gain code |
| peak_line | output | 1 | Previous line requested a white-peak reduction |
| tip_floor | output | 1 | Previous line's window minimum was 0 |

## Verification
The bench builds the block with a 4-bit gain code, a raise step of 1 and a reduce step of 3. With these values the midpoint is 8. Both saturation limits are reached within a dozen lines, and a reduction from 2 shows that the floor clamps a step that does not divide evenly. The 248 ceiling and 8-bit samples stay at their defaults, so the boundary samples 248 and 249 are driven exactly.

// File: rtl/sync_agc_pkg.sv
package sync_agc_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_RAISE = 2'd1,
      ACT_LOWER = 2'd2
   } gain_act_t;

endpackage

// File: rtl/sync_agc_tipmin.sv
module sync_agc_tipmin #(
   parameter int SAMPLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                tip_win,
   input  logic                line_stb,
   output logic                tip_seen,
   output logic [SAMPLE_W-1:0] tip_min
);

   localparam logic [SAMPLE_W-1:0] MIN_INIT = {SAMPLE_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tip_seen <= 1'b0;
         tip_min  <= MIN_INIT;
      end else if (line_stb) begin
         tip_seen <= 1'b0;
         tip_min  <= MIN_INIT;
      end else if (tip_win) begin
         tip_seen <= 1'b1;
         if (sample_in < tip_min) begin
            tip_min <= sample_in;
         end
      end
   end

endmodule

// File: rtl/sync_agc_peak.sv
module sync_agc_peak #(
   parameter int SAMPLE_W   = 8,
   parameter int PEAK_LEVEL = 248
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                peak_en,
   input  logic                line_stb,
   output logic                peak_hit
);

   localparam int FULL_SCALE = (1 << SAMPLE_W) - 1;

   generate
      if (PEAK_LEVEL >= FULL_SCALE) begin : g_never
         // No sample can exceed full scale: the detector is absent.
         assign peak_hit = 1'b0;
      end else begin : g_detect
         localparam logic [SAMPLE_W-1:0] LEVEL = SAMPLE_W'(PEAK_LEVEL);
         logic hit_q;
         logic over;

         assign over = peak_en && (sample_in > LEVEL);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hit_q <= 1'b0;
            end else if (line_stb) begin
               hit_q <= 1'b0;
            end else if (over) begin
               hit_q <= 1'b1;
            end
         end

         assign peak_hit = hit_q;
      end
   endgenerate

endmodule

// File: rtl/sync_agc_gain.sv
module sync_agc_gain
   import sync_agc_pkg::*;
#(
   parameter int GAIN_W    = 8,
   parameter int TIP_STEP  = 1,
   parameter int PEAK_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   input  gain_act_t         act,
   output logic [GAIN_W-1:0] gain_code
);

   localparam logic [GAIN_W-1:0] GAIN_MID  = GAIN_W'(1 << (GAIN_W - 1));
   localparam logic [GAIN_W-1:0] GAIN_MAX  = {GAIN_W{1'b1}};
   localparam logic [GAIN_W:0]   UP_STEP   = (GAIN_W + 1)'(TIP_STEP);
   localparam logic [GAIN_W-1:0] DOWN_STEP = GAIN_W'(PEAK_STEP);

   logic [GAIN_W:0]   up_sum;
   logic [GAIN_W-1:0] up_sat;
   logic [GAIN_W-1:0] down_sat;
   logic [GAIN_W-1:0] gain_nxt;

   assign up_sum   = {1'b0, gain_code} + UP_STEP;
   assign up_sat   = (up_sum > {1'b0, GAIN_MAX}) ? GAIN_MAX : up_sum[GAIN_W-1:0];
   assign down_sat = (gain_code < DOWN_STEP) ? '0 : (gain_code - DOWN_STEP);

   always_comb begin
      case (act)
         ACT_RAISE: gain_nxt = up_sat;
         ACT_LOWER: gain_nxt = down_sat;
         default:   gain_nxt = gain_code;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_code <= GAIN_MID;
      end else if (line_stb) begin
         gain_code <= gain_nxt;
      end
   end

endmodule

// File: rtl/sync_agc.sv
module sync_agc
   import sync_agc_pkg::*;
#(
   parameter int SAMPLE_W   = 8,
   parameter int GAIN_W     = 8,
   parameter int TIP_STEP   = 1,
   parameter int PEAK_STEP  = 1,
   parameter int PEAK_LEVEL = 248
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                tip_win,
   input  logic                line_stb,
   input  logic                peak_en,
   output logic [GAIN_W-1:0]   gain_code,
   output logic                peak_line,
   output logic                tip_floor
);

   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 16) begin : g_bad_sample_w
         $error("sync_agc: SAMPLE_W must lie in 2..16");
      end
      if (GAIN_W < 2 || GAIN_W > 16) begin : g_bad_gain_w
         $error("sync_agc: GAIN_W must lie in 2..16");
      end
      if (TIP_STEP < 1 || TIP_STEP >= (1 << GAIN_W)) begin : g_bad_tip_step
         $error("sync_agc: TIP_STEP must be at least 1 and below the gain range");
      end
      if (PEAK_STEP < 1 || PEAK_STEP >= (1 << GAIN_W)) begin : g_bad_peak_step
         $error("sync_agc: PEAK_STEP must be at least 1 and below the gain range");
      end
      if (PEAK_LEVEL < 0 || PEAK_LEVEL >= (1 << SAMPLE_W)) begin : g_bad_level
         $error("sync_agc: PEAK_LEVEL must be a valid sample code");
      end
   endgenerate

   logic                tip_seen;
   logic [SAMPLE_W-1:0] tip_min;
   logic                peak_hit;
   logic                tip_zero;
   gain_act_t           act;

   sync_agc_tipmin #(
      .SAMPLE_W (SAMPLE_W)
   ) u_tipmin (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_in (sample_in),
      .tip_win   (tip_win),
      .line_stb  (line_stb),
      .tip_seen  (tip_seen),
      .tip_min   (tip_min)
   );

   sync_agc_peak #(
      .SAMPLE_W   (SAMPLE_W),
      .PEAK_LEVEL (PEAK_LEVEL)
   ) u_peak (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_in (sample_in),
      .peak_en   (peak_en),
      .line_stb  (line_stb),
      .peak_hit  (peak_hit)
   );

   assign tip_zero = tip_seen && (tip_min == '0);

   // White-peak reduction outranks the sync-tip raise.
   always_comb begin
      if (peak_hit) begin
         act = ACT_LOWER;
      end else if (tip_seen && !tip_zero) begin
         act = ACT_RAISE;
      end else begin
         act = ACT_HOLD;
      end
   end

   sync_agc_gain #(
      .GAIN_W    (GAIN_W),
      .TIP_STEP  (TIP_STEP),
      .PEAK_STEP (PEAK_STEP)
   ) u_gain (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_stb  (line_stb),
      .act       (act),
      .gain_code (gain_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_line <= 1'b0;
         tip_floor <= 1'b0;
      end else if (line_stb) begin
         peak_line <= peak_hit;
         tip_floor <= tip_zero;
      end
   end

endmodule

// File: rtl/sync_agc_chk.sv
module sync_agc_chk #(
   parameter int GAIN_W    = 8,
   parameter int TIP_STEP  = 1,
   parameter int PEAK_STEP = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_stb,
   input logic [GAIN_W-1:0] gain_code,
   input logic              peak_line,
   input logic              tip_floor
);

   localparam logic [GAIN_W-1:0] UP_D   = GAIN_W'(TIP_STEP);
   localparam logic [GAIN_W-1:0] DOWN_D = GAIN_W'(PEAK_STEP);

   AST_GAIN_HOLDS_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(gain_code)); // R9

   AST_FLAGS_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> ($stable(peak_line) && $stable(tip_floor))); // R9

   AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> ((gain_code >= $past(gain_code))
                    ? ((gain_code - $past(gain_code)) <= UP_D)
                    : (($past(gain_code) - gain_code) <= DOWN_D))); // R8

   AST_PEAK_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> (!peak_line || (gain_code <= $past(gain_code)))); // R6

   AST_FLOOR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> (!tip_floor || (gain_code <= $past(gain_code)))); // R3

   AST_LOWER_ONLY_ON_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> (peak_line || (gain_code >= $past(gain_code)))); // R5

endmodule

bind sync_agc sync_agc_chk #(
   .GAIN_W    (GAIN_W),
   .TIP_STEP  (TIP_STEP),
   .PEAK_STEP (PEAK_STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_stb  (line_stb),
   .gain_code (gain_code),
   .peak_line (peak_line),
   .tip_floor (tip_floor)
);

// File: tb/sync_agc_test.sv
`timescale 1ns/1ps
module sync_agc_test;

   localparam int GW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    sample_in = '0;
   logic          tip_win = 1'b0;
   logic          line_stb = 1'b0;
   logic          peak_en = 1'b0;
   logic [GW-1:0] gain_code;
   logic          peak_line;
   logic          tip_floor;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sync_agc #(
      .SAMPLE_W (8), .GAIN_W (GW), .TIP_STEP (1), .PEAK_STEP (3), .PEAK_LEVEL (248)
   ) uut (
      .clk (clk), .rst_n (rst_n), .sample_in (sample_in), .tip_win (tip_win),
      .line_stb (line_stb), .peak_en (peak_en), .gain_code (gain_code),
      .peak_line (peak_line), .tip_floor (tip_floor)
   );

   typedef struct packed {
      logic [7:0]    tip;
      logic [7:0]    pic;
      logic          en;
      logic [GW-1:0] gain;
      logic          pk;
      logic          fl;
   } vec_t;

   // Gain starts at 8; raise +1, reduce -3, clamp to 0..15.
   localparam vec_t VECS [11] = '{
      '{8'd10, 8'd100, 1'b1, 4'd9,  1'b0, 1'b0},  // R2 raise
      '{8'd3,  8'd248, 1'b1, 4'd10, 1'b0, 1'b0},  // R5 exactly 248 ignored
      '{8'd3,  8'd249, 1'b1, 4'd7,  1'b1, 1'b0},  // R6 peak beats raise
      '{8'd0,  8'd200, 1'b1, 4'd7,  1'b0, 1'b1},  // R3 tip at zero
      '{8'd0,  8'd255, 1'b0, 4'd7,  1'b0, 1'b1},  // R7 disabled
      '{8'd5,  8'd255, 1'b0, 4'd8,  1'b0, 1'b0},  // R7 disabled, raise
      '{8'd0,  8'd255, 1'b1, 4'd5,  1'b1, 1'b1},  // R5
      '{8'd0,  8'd250, 1'b1, 4'd2,  1'b1, 1'b1},  // R5
      '{8'd0,  8'd251, 1'b1, 4'd0,  1'b1, 1'b1},  // R8 floor clamps
      '{8'd0,  8'd252, 1'b1, 4'd0,  1'b1, 1'b1},  // R10 flag at floor
      '{8'd1,  8'd0,   1'b1, 4'd1,  1'b0, 1'b0}   // R2 from floor
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Two window cycles, two picture cycles, then the strobe; returns one
   // falling edge after the strobe edge.
   task automatic run_line(input logic [7:0] tip, input logic [7:0] pic,
                           input logic en, input logic use_win);
      @(negedge clk); peak_en = en; tip_win = use_win; sample_in = tip + 8'd5;
      @(negedge clk); sample_in = tip;
      @(negedge clk); tip_win = 1'b0; sample_in = pic;
      @(negedge clk); sample_in = 8'd10;
      @(negedge clk); line_stb = 1'b1; sample_in = 8'd0;
      @(negedge clk); line_stb = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R9: watchdog expired, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 gain after reset", int'(gain_code), 8);
      check("R1 peak_line after reset", int'(peak_line), 0);
      check("R1 tip_floor after reset", int'(tip_floor), 0);
      rst_n = 1'b1;

      foreach (VECS[i]) begin
         run_line(VECS[i].tip, VECS[i].pic, VECS[i].en, 1'b1);
         check($sformatf("R2/R5 row %0d gain", i), int'(gain_code), int'(VECS[i].gain));
         check($sformatf("R10 row %0d peak_line", i), int'(peak_line), int'(VECS[i].pk));
         check($sformatf("R3 row %0d tip_floor", i), int'(tip_floor), int'(VECS[i].fl));
      end

      // R2: zero samples outside the window do not hold the gain down.
      run_line(8'd20, 8'd0, 1'b1, 1'b1);
      check("R2 outside-window zero ignored", int'(gain_code), 2);

      // R4: no window samples, no sync-tip change.
      run_line(8'd50, 8'd50, 1'b1, 1'b0);
      check("R4 no window gain", int'(gain_code), 2);
      check("R4 no window tip_floor", int'(tip_floor), 0);

      // R7: over-range sample while disabled, enable raised later.
      @(negedge clk); peak_en = 1'b1; tip_win = 1'b1; sample_in = 8'd5;
      @(negedge clk); tip_win = 1'b0; peak_en = 1'b0; sample_in = 8'd255;
      @(negedge clk); peak_en = 1'b1; sample_in = 8'd100;
      @(negedge clk); line_stb = 1'b1; sample_in = 8'd0;
      @(negedge clk); line_stb = 1'b0;
      check("R7 enable per sample gain", int'(gain_code), 3);
      check("R7 enable per sample peak_line", int'(peak_line), 0);

      // R8: ceiling.
      for (int k = 0; k < 12; k++) run_line(8'd1, 8'd0, 1'b1, 1'b1);
      check("R8 reach ceiling", int'(gain_code), 15);
      run_line(8'd1, 8'd0, 1'b1, 1'b1);
      check("R8 hold at ceiling", int'(gain_code), 15);

      // R9: mid-line over-range changes nothing until the strobe.
      @(negedge clk); peak_en = 1'b1; sample_in = 8'd255;
      @(negedge clk); sample_in = 8'd10;
      @(negedge clk);
      check("R9 gain held before strobe", int'(gain_code), 15);
      check("R9 flag held before strobe", int'(peak_line), 0);
      line_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0;
      check("R5 reduce from ceiling", int'(gain_code), 12);
      check("R10 flag after reduce", int'(peak_line), 1);

      // R1: reset mid-run.
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 gain after second reset", int'(gain_code), 8);
      check("R1 flag after second reset", int'(peak_line), 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule